// File: doc/BRIEF.md
# Eight-Function Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit whose operand and result width is set by a parameter. It takes two operands and a three-bit function code and returns a result of the same width. The code selects one of eight operations: four arithmetic (sum, difference, increment of the first operand, increment of the second operand) and four bitwise (conjunction, disjunction, exclusive-or, inversion of the first operand). Arithmetic results wrap modulo 2^WIDTH.

Two flags come with every result. The carry flag is the bit above the result for the arithmetic codes; for the difference it reads as "no borrow". For the bitwise codes it is forced low. The zero flag is set whenever the result is all zeros, whatever code is selected.

A second parameter picks how the arithmetic path is built: as an explicit bit-serial ripple chain or as a single behavioural adder. Both build variants must give identical results.

Top module: `alu_core`

## Requirements
- R1: Function code 3'b000 gives result = (A + B) mod 2^WIDTH, and carry = bit WIDTH of the full sum A + B.
- R2: Function code 3'b001 gives result = (A - B) mod 2^WIDTH, and carry = 1 exactly when A >= B (no borrow).
- R3: Function code 3'b010 gives result = (A + 1) mod 2^WIDTH, and carry = 1 exactly when A is all ones. B has no effect.
- R4: Function code 3'b011 gives result = (B + 1) mod 2^WIDTH, and carry = 1 exactly when B is all ones. A has no effect.
- R5: Function codes 3'b100, 3'b101 and 3'b110 give the bitwise AND, OR and XOR of A and B.
- R6: Function code 3'b111 gives the bitwise inversion of A. B has no effect.
- R7: For every function code with bit 2 set, the carry output is 0.
- R8: For every function code, the zero flag is 1 exactly when the result is all zeros.
- R9: The behaviour in R1 to R8 holds for any WIDTH of at least 1, and holds the same for both arithmetic build variants (RIPPLE = 1 and RIPPLE = 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First operand |
| opnd_b | input | WIDTH | Second operand |
| func_sel | input | 3 | Function code, encoding as in R1 to R6 |
| result | output | WIDTH | Result of the selected function |
| carry_out | output | 1 | Carry, or no-borrow for the difference; 0 for bitwise codes |
| zero_out | output | 1 | High when the result is all zeros |

## Verification
The assertions are immediate checks evaluated whenever the combinational logic changes, and they assume the operands and the function code are fully known; each one skips evaluation while any of these inputs carries X or Z. The stimulus drives every input from the start of the run, so the guard only covers the moment before the first drive. Operands are drawn from a seeded generator and masked to each instance's width, so no out-of-range value ever reaches the block, and the directed corners (all zeros, all ones, equal operands, A one below B) are chosen inside that range.

// File: rtl/alu_pkg.sv
package alu_pkg;

   typedef enum logic [2:0] {
      OP_ADD   = 3'b000,
      OP_SUB   = 3'b001,
      OP_INC_A = 3'b010,
      OP_INC_B = 3'b011,
      OP_AND   = 3'b100,
      OP_OR    = 3'b101,
      OP_XOR   = 3'b110,
      OP_NOT_A = 3'b111
   } alu_op_e;

   // Bit 2 of the code separates the bitwise group from the arithmetic group.
   function automatic logic op_is_bitwise(input alu_op_e op);
      return op[2];
   endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
   import alu_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  alu_op_e          op,
   output logic [WIDTH-1:0] sum,
   output logic             cout
);

   localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] NONE     = '0;

   logic [WIDTH-1:0] x_in;
   logic [WIDTH-1:0] y_in;
   logic             c_in;

   // Operand conditioning: one adder serves all four arithmetic codes.
   always_comb begin
      x_in = NONE;
      y_in = NONE;
      c_in = 1'b0;
      case (op)
         OP_ADD:   begin x_in = a; y_in = b;  c_in = 1'b0; end
         OP_SUB:   begin x_in = a; y_in = ~b; c_in = 1'b1; end
         OP_INC_A: begin x_in = a; y_in = NONE; c_in = 1'b1; end
         OP_INC_B: begin x_in = b; y_in = NONE; c_in = 1'b1; end
         default:  begin x_in = NONE; y_in = NONE; c_in = 1'b0; end
      endcase
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] chain;
         assign chain[0] = c_in;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum[i]     = x_in[i] ^ y_in[i] ^ chain[i];
            assign chain[i+1] = (x_in[i] & y_in[i]) |
                                (chain[i] & (x_in[i] ^ y_in[i]));
         end
         assign cout = chain[WIDTH];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide = {1'b0, x_in} + {1'b0, y_in} + {{WIDTH{1'b0}}, c_in};
         assign sum  = wide[WIDTH-1:0];
         assign cout = wide[WIDTH];
      end
   endgenerate

   always_comb begin
      if (!$isunknown({a, b, op})) begin
         if (op == OP_SUB)
            AST_SUB_NO_BORROW: assert (cout == (a >= b)); // R2
         if (op == OP_INC_A && a == ALL_ONES)
            AST_INC_WRAP: assert (sum == NONE && cout); // R3
      end
   end

endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic [1:0]       fn,
   output logic [WIDTH-1:0] res
);

   localparam logic [1:0] FN_AND = 2'b00;
   localparam logic [1:0] FN_OR  = 2'b01;
   localparam logic [1:0] FN_XOR = 2'b10;

   for (genvar i = 0; i < WIDTH; i++) begin : g_lane
      always_comb begin
         case (fn)
            FN_AND:  res[i] = a[i] & b[i];
            FN_OR:   res[i] = a[i] | b[i];
            FN_XOR:  res[i] = a[i] ^ b[i];
            default: res[i] = ~a[i];
         endcase
      end
   end

   always_comb begin
      if (!$isunknown({a, b, fn}) && fn == FN_XOR)
         AST_XOR_DISJOINT: assert ((res & a & b) == '0); // R5
   end

endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] res,
   output logic             zero
);

   assign zero = ~|res;

endmodule

// File: rtl/alu_core.sv
module alu_core
   import alu_pkg::*;
#(
   parameter int WIDTH  = 16,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [2:0]       func_sel,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             zero_out
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("alu_core: WIDTH must be at least 1");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] arith_sum;
   logic             arith_cout;
   logic [WIDTH-1:0] logic_res;

   assign op = alu_op_e'(func_sel);

   alu_arith #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_arith (
      .a    (opnd_a),
      .b    (opnd_b),
      .op   (op),
      .sum  (arith_sum),
      .cout (arith_cout)
   );

   alu_bitwise #(.WIDTH(WIDTH)) u_bitwise (
      .a   (opnd_a),
      .b   (opnd_b),
      .fn  (func_sel[1:0]),
      .res (logic_res)
   );

   assign result    = op_is_bitwise(op) ? logic_res : arith_sum;
   assign carry_out = op_is_bitwise(op) ? 1'b0 : arith_cout;

   alu_flags #(.WIDTH(WIDTH)) u_flags (
      .res  (result),
      .zero (zero_out)
   );

   always_comb begin
      if (!$isunknown({opnd_a, opnd_b, func_sel})) begin
         if (op == OP_ADD)
            AST_ADD_SUM: assert ({carry_out, result} ==
                                 ({1'b0, opnd_a} + {1'b0, opnd_b})); // R1
         if (op_is_bitwise(op))
            AST_BITWISE_NO_CARRY: assert (!carry_out); // R7
         if (zero_out)
            AST_ZERO_MEANS_EMPTY: assert (result == '0); // R8
      end
   end

endmodule

// File: tb/alu_core_test.sv
module alu_core_test;

   localparam int W0 = 16;
   localparam int W1 = 5;
   localparam int W2 = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [W0-1:0] a0, b0, r0;
   logic [W1-1:0] a1, b1, r1;
   logic [W2-1:0] a2, b2, r2;
   logic [2:0]    sel;
   logic          c0, z0, c1, z1, c2, z2;

   alu_core #(.WIDTH(W0), .RIPPLE(1'b1)) uut (
      .opnd_a(a0), .opnd_b(b0), .func_sel(sel),
      .result(r0), .carry_out(c0), .zero_out(z0));

   alu_core #(.WIDTH(W1), .RIPPLE(1'b0)) uut_w5 (
      .opnd_a(a1), .opnd_b(b1), .func_sel(sel),
      .result(r1), .carry_out(c1), .zero_out(z1));

   alu_core #(.WIDTH(W2), .RIPPLE(1'b1)) uut_w1 (
      .opnd_a(a2), .opnd_b(b2), .func_sel(sel),
      .result(r2), .carry_out(c2), .zero_out(z2));

   function automatic string req_of(input logic [2:0] s);
      case (s)
         3'b000: return "R1";
         3'b001: return "R2";
         3'b010: return "R3";
         3'b011: return "R4";
         3'b111: return "R6";
         default: return "R5";
      endcase
   endfunction

   // Reference model: returns {carry, result} for width w, in 64-bit arithmetic.
   function automatic longint unsigned ref_model(input logic [2:0] s,
         input longint unsigned a, input longint unsigned b, input int w);
      longint unsigned m, full, res, cy;
      m = (64'd1 << w) - 1;
      cy = 0;
      case (s)
         3'b000: begin full = a + b; res = full & m; cy = (full >> w) & 1; end
         3'b001: begin res = (a - b) & m; cy = (a >= b) ? 1 : 0; end
         3'b010: begin res = (a + 1) & m; cy = (a == m) ? 1 : 0; end
         3'b011: begin res = (b + 1) & m; cy = (b == m) ? 1 : 0; end
         3'b100: res = a & b;
         3'b101: res = a | b;
         3'b110: res = a ^ b;
         default: res = (~a) & m;
      endcase
      return (cy << 32) | res;
   endfunction

   task automatic compare(input string tag, input int w, input logic [2:0] s,
         input longint unsigned a, input longint unsigned b,
         input longint unsigned got_r, input logic got_c, input logic got_z);
      longint unsigned e, er;
      logic ec, ez;
      e  = ref_model(s, a, b, w);
      er = e & 64'hFFFF_FFFF;
      ec = e[32];
      ez = (er == 0);
      n_tests++;
      if (got_r !== er || got_c !== ec) begin
         n_fail++;
         $display("FAIL %s (R9 w=%0d) sel=%b a=%0h b=%0h: got r=%0h c=%0b, expected r=%0h c=%0b",
                  tag, w, s, a, b, got_r, got_c, er, ec);
      end
      n_tests++;
      if (got_z !== ez) begin
         n_fail++;
         $display("FAIL R8 w=%0d sel=%b a=%0h b=%0h: got zero=%0b, expected %0b",
                  w, s, a, b, got_z, ez);
      end
   endtask

   task automatic apply(input logic [2:0] s, input longint unsigned a,
                        input longint unsigned b);
      @(negedge clk);
      sel = s;
      a0 = a[W0-1:0]; b0 = b[W0-1:0];
      a1 = a[W1-1:0]; b1 = b[W1-1:0];
      a2 = a[W2-1:0]; b2 = b[W2-1:0];
      #2;
      compare(req_of(s), W0, s, longint'(a0), longint'(b0), longint'(r0), c0, z0);
      compare(req_of(s), W1, s, longint'(a1), longint'(b1), longint'(r1), c1, z1);
      compare(req_of(s), W2, s, longint'(a2), longint'(b2), longint'(r2), c2, z2);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired: got hung run, expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      longint unsigned ones;
      logic [31:0] seed_dummy;
      sel = 3'b000;
      a0 = '0; b0 = '0; a1 = '0; b1 = '0; a2 = '0; b2 = '0;
      seed_dummy = $urandom(32'd20240611);
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // Idle state: zero operands with the add code -> zero result, zero flag set (R1, R8)
      compare("R1", W0, 3'b000, 0, 0, longint'(r0), c0, z0);

      ones = 64'hFFFF_FFFF;
      for (int s = 0; s < 8; s++) begin
         apply(3'(s), 0, 0);
         apply(3'(s), ones, ones);
         apply(3'(s), ones, 0);
         apply(3'(s), 0, ones);
         apply(3'(s), 64'h1234, 64'h1234);
         apply(3'(s), 64'h0FFE, 64'h0FFF);
      end
      // R7: bitwise codes with operands that would carry
      apply(3'b100, ones, 1);
      apply(3'b101, ones, ones);
      // R4 / R6: second operand has no effect on inversion, first none on inc-B
      apply(3'b111, 64'h00A5, 64'h5A5A);
      apply(3'b011, 64'h7777, 64'hFFFF);

      for (int k = 0; k < 400; k++) begin
         for (int s = 0; s < 8; s++) begin
            apply(3'(s), longint'($urandom), longint'($urandom));
         end
      end

      done = 1'b1;
      if (seed_dummy == 32'hFFFF_FFFF) $display("seed note");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule